// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control of an 8-bit successive-approximation converter that never stops. It holds the selected input channel, runs a fixed 30-cycle frame, and then starts the next frame at once. A frame opens with a sampling window and ends with one trial per result bit. The trial code goes out to an external DAC and comparator, and a single comparator bit comes back. When a frame ends, the code goes into a result register and a sticky completion flag is raised.

Software sees two read views and one write port. The control view reports the flag in bit 7 and the channel in the low bits. The result view returns the last finished code. A write to the control register selects a new channel, clears the flag and throws away the frame in progress, so the next frame begins with a fresh sampling window on the new channel.

Top module: `sar_seq_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ctl_rdata` reads 0 (channel 0, flag clear), `res_rdata` reads 0, `chan_sel` is 0 and `sample` is 1.
- R2: Each frame lasts exactly 30 cycles. `sample` is 1 and `trial_code` is 0 for the first 22 cycles. `sample` is 0 for the following 8 cycles. Frames follow each other with no gap.
- R3: In resolution step k (k = 0..7), `trial_code` equals the bits already decided, plus bit 7−k set, with all lower bits 0. A trial bit is kept when `cmp_in` is 1 in that step.
- R4: On the clock edge that ends the last step, `res_rdata` loads the resolved code and `ctl_rdata` bit 7 becomes 1. `sample` is 1 in the cycle that follows.
- R5: `res_rdata` changes only when a frame completes.
- R6: When `ctl_wr` is high, `chan_sel` and `ctl_rdata[1:0]` take `ctl_wdata[1:0]` on the next edge. The flag clears, a new sampling window starts, and `res_rdata` is unchanged.
- R7: A write in the last step of a frame takes priority. No result is loaded and the flag stays clear.
- R8: `ctl_rdata` bits 6..2 always read 0.
- R9: The comparator answers 1 when the input is at or above (c−½) LSB for trial code c. With that comparator, the result is the input rounded to the nearest LSB, saturated at FF. A zero input gives 00, ½ LSB gives 01, and 1½ LSB below full scale gives FF.
- R10: Once set, the flag stays set through later completions until a control write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; low bits select the channel |
| ctl_rdata | output | 8 | Control read: bit 7 completion flag, low bits channel |
| res_rdata | output | 8 | Last completed conversion code |
| chan_sel | output | 2 | Channel select for the analog multiplexer |
| sample | output | 1 | High during the sampling window |
| trial_code | output | 8 | Trial code for the DAC |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial level |

## Verification
The hardest case to reach is a control write that lands on the exact cycle in which a frame would otherwise finish. It needs a write, then exactly 29 idle cycles, then a second write. The bench's cycle-accurate reference model counts frame positions, so the stimulus can place the second write there on purpose. The saturating top codes and the ½-LSB bottom code are reached by giving the modelled channels input levels of 0, 1, 508, 509 and 511 half-LSB units.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Software-visible control register layout
    localparam int CTL_W    = 8;
    localparam int FLAG_BIT = 7;

    // Position of the frame counter within a frame
    typedef struct packed {
        logic sampling;   // sampling window active
        logic resolving;  // one trial per cycle
        logic last;       // final trial of the frame
    } sar_phase_t;

    // Pack flag and channel into the control read view
    function automatic logic [CTL_W-1:0] pack_ctl(input logic flag,
                                                  input logic [CTL_W-2:0] chan_ext);
        logic [CTL_W-1:0] v;
        v = {1'b0, chan_ext};
        v[FLAG_BIT] = flag;
        return v;
    endfunction

endpackage

// File: rtl/sar_timebase.sv
module sar_timebase
    import sar_seq_pkg::*;
#(
    parameter int CONV_CYC = 30,
    parameter int RES_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       restart,
    output sar_phase_t                 phase,
    output logic [$clog2(RES_W)-1:0]   bit_pos
);
    localparam int SAMP_CYC = CONV_CYC - RES_W;
    localparam int CNT_W    = $clog2(CONV_CYC);
    localparam int POS_W    = $clog2(RES_W);

    logic [CNT_W-1:0] cyc_q;
    logic             at_end;

    assign at_end = (cyc_q == CNT_W'(CONV_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cyc_q <= '0;
        end else if (at_end) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    always_comb begin
        phase.sampling  = (cyc_q < CNT_W'(SAMP_CYC));
        phase.resolving = !phase.sampling;
        phase.last      = at_end;
        bit_pos = '0;
        if (phase.resolving) begin
            bit_pos = POS_W'(RES_W - 1 - (int'(cyc_q) - SAMP_CYC));
        end
    end

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int RES_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       restart,
    input  logic                       resolving,
    input  logic                       last,
    input  logic [$clog2(RES_W)-1:0]   bit_pos,
    input  logic                       cmp,
    output logic [RES_W-1:0]           trial,
    output logic [RES_W-1:0]           final_code
);
    localparam int POS_W = $clog2(RES_W);

    logic [RES_W-1:0] bits_q;
    logic [RES_W-1:0] probe;
    logic             clr;

    assign clr = rst || restart || (resolving && last);

    // One decision flop per result bit
    for (genvar i = 0; i < RES_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (clr) begin
                bits_q[i] <= 1'b0;
            end else if (resolving && cmp && (bit_pos == POS_W'(i))) begin
                bits_q[i] <= 1'b1;
            end
        end
        assign probe[i] = resolving && (bit_pos == POS_W'(i));
    end

    assign trial      = resolving ? (bits_q | probe) : '0;
    assign final_code = bits_q | (cmp ? probe : '0);

endmodule

// File: rtl/sar_ctl_regs.sv
module sar_ctl_regs
    import sar_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr,
    input  logic [CTL_W-1:0]            wdata,
    input  logic                        done,
    input  logic [RES_W-1:0]            code,
    output logic [$clog2(NUM_CH)-1:0]   chan,
    output logic [CTL_W-1:0]            ctl_view,
    output logic [RES_W-1:0]            res_view
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [CH_W-1:0]  chan_q;
    logic             flag_q;
    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            flag_q <= 1'b0;
            res_q  <= '0;
        end else if (wr) begin
            chan_q <= wdata[CH_W-1:0];
            flag_q <= 1'b0;
        end else if (done) begin
            res_q  <= code;
            flag_q <= 1'b1;
        end
    end

    assign chan     = chan_q;
    assign res_view = res_q;
    assign ctl_view = pack_ctl(flag_q, (CTL_W-1)'(chan_q));

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int RES_W    = 8,
    parameter int CONV_CYC = 30
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ctl_wr,
    input  logic [CTL_W-1:0]            ctl_wdata,
    output logic [CTL_W-1:0]            ctl_rdata,
    output logic [RES_W-1:0]            res_rdata,
    output logic [$clog2(NUM_CH)-1:0]   chan_sel,
    output logic                        sample,
    output logic [RES_W-1:0]            trial_code,
    input  logic                        cmp_in
);
    localparam int POS_W = $clog2(RES_W);

    sar_phase_t       phase;
    logic [POS_W-1:0] bit_pos;
    logic [RES_W-1:0] final_code;
    logic             conv_last;

    assign conv_last = phase.resolving && phase.last;

    sar_timebase #(.CONV_CYC(CONV_CYC), .RES_W(RES_W)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .restart (ctl_wr),
        .phase   (phase),
        .bit_pos (bit_pos)
    );

    sar_approx_reg #(.RES_W(RES_W)) u_sar (
        .clk        (clk),
        .rst        (rst),
        .restart    (ctl_wr),
        .resolving  (phase.resolving),
        .last       (phase.last),
        .bit_pos    (bit_pos),
        .cmp        (cmp_in),
        .trial      (trial_code),
        .final_code (final_code)
    );

    sar_ctl_regs #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .done     (conv_last),
        .code     (final_code),
        .chan     (chan_sel),
        .ctl_view (ctl_rdata),
        .res_view (res_rdata)
    );

    assign sample = phase.sampling;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      ctl_wr,
    input logic [7:0]                ctl_rdata,
    input logic [RES_W-1:0]          res_rdata,
    input logic                      sample,
    input logic [RES_W-1:0]          trial_code,
    input logic                      conv_last
);
    localparam int CH_W = $clog2(NUM_CH);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (ctl_rdata == 8'h00 && res_rdata == '0)); // R1
    AST_SAMPLE_ZERO_TRIAL: assert property (@(posedge clk) disable iff (rst) sample |-> (trial_code == '0)); // R2
    AST_RESOLVE_TRIAL_NONZERO: assert property (@(posedge clk) disable iff (rst) !sample |-> (trial_code != '0)); // R3
    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst) (conv_last && !ctl_wr) |=> (ctl_rdata[7] && sample)); // R4
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst) !(conv_last && !ctl_wr) |=> $stable(res_rdata)); // R5
    AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (rst) ctl_wr |=> (!ctl_rdata[7] && sample)); // R6
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst) (ctl_wr && conv_last) |=> $stable(res_rdata)); // R7
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst) ctl_rdata[6:CH_W] == '0); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (ctl_rdata[7] && !ctl_wr) |=> ctl_rdata[7]); // R10

endmodule

bind sar_seq_top sar_seq_chk #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr     (ctl_wr),
    .ctl_rdata  (ctl_rdata),
    .res_rdata  (res_rdata),
    .sample     (sample),
    .trial_code (trial_code),
    .conv_last  (conv_last)
);

// File: tb/sim_sar_seq_top.sv
`timescale 1ns/1ps
module sim_sar_seq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic [7:0] res_rdata;
    logic [1:0] chan_sel;
    logic       sample;
    logic [7:0] trial_code;
    logic       cmp_in;

    int vin [4];   // input levels in half-LSB units, 0..511
    int errors = 0;
    int checks = 0;

    // reference model state
    int m_cyc = 0;
    int m_ch = 0;
    int m_flag = 0;
    int m_res = 0;

    always #2.5 clk = ~clk;

    // Behavioural comparator: code c threshold at (c - 1/2) LSB
    assign cmp_in = (vin[chan_sel] >= 2 * int'(trial_code) - 1);

    sar_seq_top u0 (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .ctl_rdata  (ctl_rdata),
        .res_rdata  (res_rdata),
        .chan_sel   (chan_sel),
        .sample     (sample),
        .trial_code (trial_code),
        .cmp_in     (cmp_in)
    );

    function automatic int exp_code(input int v);
        int r;
        r = (v + 1) / 2;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int e;
        int k;
        int t;
        chk("R2 sample", int'(sample), (m_cyc < 22) ? 1 : 0);
        if (m_cyc >= 22) begin
            k = m_cyc - 22;
            e = exp_code(vin[m_ch]);
            t = ((e >> (8 - k)) << (8 - k)) | (1 << (7 - k));
        end else begin
            t = 0;
        end
        chk("R3 trial", int'(trial_code), t);
        chk("R4 flag", int'(ctl_rdata[7]), m_flag);
        chk("R5 result", int'(res_rdata), m_res);
        chk("R8 control view", int'(ctl_rdata[6:0]), m_ch);
        chk("R6 chan_sel", int'(chan_sel), m_ch);
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic tick(input logic wr, input logic [7:0] data);
        ctl_wr    = wr;
        ctl_wdata = data;
        @(posedge clk);
        if (rst) begin
            m_cyc = 0; m_ch = 0; m_flag = 0; m_res = 0;
        end else if (wr) begin
            m_ch = int'(data[1:0]); m_flag = 0; m_cyc = 0;
        end else if (m_cyc == 29) begin
            m_res = exp_code(vin[m_ch]); m_flag = 1; m_cyc = 0;
        end else begin
            m_cyc++;
        end
        @(negedge clk);
        ctl_wr = 1'b0;
        compare_all();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 8'h00);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int hold;
        vin[0] = 0; vin[1] = 300; vin[2] = 509; vin[3] = 511;
        @(negedge clk);
        run(3);
        chk("R1 reset control", int'(ctl_rdata), 0);
        chk("R1 reset result", int'(res_rdata), 0);
        rst = 1'b0;
        tick(1'b0, 8'h00);
        chk("R1 after reset sample", int'(sample), 1);
        run(34);                                  // first frame on channel 0
        chk("R9 zero input", int'(res_rdata), 0);
        tick(1'b1, 8'h01); run(30);
        chk("R9 mid input", int'(res_rdata), 150);
        run(30);
        chk("R10 flag kept", int'(ctl_rdata[7]), 1);
        tick(1'b1, 8'hFE);                        // channel 2 through low bits
        chk("R6 write clears flag", int'(ctl_rdata[7]), 0);
        chk("R6 result untouched", int'(res_rdata), 150);
        run(30);
        chk("R9 1.5 LSB below top", int'(res_rdata), 255);
        tick(1'b1, 8'h03); run(30);
        chk("R9 full scale", int'(res_rdata), 255);
        vin[0] = 1;
        tick(1'b1, 8'h00); run(30);
        chk("R9 half LSB", int'(res_rdata), 1);
        vin[1] = 508;
        tick(1'b1, 8'h01); run(30);
        chk("R9 near top", int'(res_rdata), 254);
        vin[1] = 301;
        tick(1'b1, 8'h01); run(29);               // now in the last step
        hold = int'(res_rdata);
        vin[2] = 100;
        tick(1'b1, 8'h02);                        // R7 collision
        chk("R7 no load", int'(res_rdata), hold);
        chk("R7 flag clear", int'(ctl_rdata[7]), 0);
        run(30);
        chk("R9 channel 2 new level", int'(res_rdata), 50);
        tick(1'b1, 8'h01); run(60);
        chk("R4 repeated frames", int'(res_rdata), 151);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule